// File: doc/BRIEF.md
# Joined-Pair Logical Right Shift Unit

This execution unit performs a 64-bit logical right shift on an operand made by joining two 32-bit registers. The accumulator supplies the upper half and the product register the lower half. A 16-bit instruction word arrives with a valid strobe. The unit decodes the word, takes the shift amount from its low four bits and produces the new register halves. It also produces the negative, zero and carry flags and the value of the repeat counter.

Words that do not carry the shift opcode are not executed, and neither are cycles with the strobe low. In those cases both register halves, all three flags and the repeat counter come back unchanged. Results are registered and appear one clock after the instruction is presented. A parameter selects one of two shifter structures: a staged logarithmic shifter or a single variable shift.

Top module: `pair_rshift_unit`

## Requirements
- R1: A word is executed only when the valid strobe is high and bits 15:4 equal 0101 0110 1001 (hex 569). `hit_out` is high in the cycle after such a word and low in the cycle after any other input.
- R2: Bits 3:0 of the word hold the shift amount minus one. The value 0000 shifts by 1, 1111 shifts by 16, and in general the value k shifts by k+1.
- R3: On execution, `{acc_out, prod_out}` equals `{acc_in, prod_in}` shifted right by the amount, with zeros entering at bit 63. `acc_in` forms bits 63:32 of the operand and `prod_in` forms bits 31:0.
- R4: On execution, `c_out` equals the last bit shifted out, which is bit (amount−1) of the 64-bit operand.
- R5: On execution, `n_out` equals bit 31 of the new accumulator half, which is bit 63 of the result.
- R6: On execution, `z_out` is 1 exactly when all 64 result bits are zero.
- R7: On execution, `rpt_out` is zero whatever value `rpt_in` holds, so the instruction runs only once.
- R8: When a word is not executed, the next outputs equal the inputs for the accumulator, product, N, Z, C and repeat count.
- R9: Outputs change only at a rising clock edge. A result appears one cycle after its instruction and does not appear before that edge.
- R10: A synchronous active-high reset clears every output to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word: opcode in bits 15:4, amount minus one in bits 3:0 |
| acc_in | input | 32 | Accumulator, upper operand half |
| prod_in | input | 32 | Product register, lower operand half |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| rpt_in | input | 8 | Current repeat count |
| acc_out | output | 32 | New accumulator |
| prod_out | output | 32 | New product register |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |
| rpt_out | output | 8 | New repeat count |
| hit_out | output | 1 | The previous cycle's word was executed |

## Verification
The operand patterns include all ones, all zeros, alternating bit patterns, an MSB-only value and a run of pseudo-random values. Each pattern is applied with all sixteen shift amounts, which separates an off-by-one in the amount decoding from a wrong fill direction. For every amount, the bench also applies an operand with only bit (amount−1) set and another with only bit (amount) set. The first must give a zero result with carry 1, and the second a result of one with carry 0. Together they pin the carry position and the zero flag at their exact boundary. Each opcode bit is then flipped on its own, and the strobe is dropped with a correct opcode. These cases show that only the exact pattern executes and that every other word passes all state through, repeat count included.

// File: rtl/pair_rshift_pkg.sv
package pair_rshift_pkg;

   localparam int PRS_HALF_W  = 32;
   localparam int PRS_INSTR_W = 16;
   localparam int PRS_CNT_W   = 4;
   localparam int PRS_RPT_W   = 8;

   localparam int PRS_STYLE_STAGED = 0;
   localparam int PRS_STYLE_DIRECT = 1;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
   } prs_flags_t;

endpackage

// File: rtl/prs_decode.sv
module prs_decode #(
   parameter int INSTR_W = 16,
   parameter int CNT_W   = 4,
   parameter logic [INSTR_W-CNT_W-1:0] OPC_VAL = 12'h569
) (
   input  logic               valid,
   input  logic [INSTR_W-1:0] word,
   output logic               hit,
   output logic [CNT_W-1:0]   amt_m1
);

   localparam int OPC_W = INSTR_W - CNT_W;

   logic [OPC_W-1:0] opc_field;

   if (OPC_W < 1) begin : g_bad_width
      $error("prs_decode: opcode field would be empty");
   end

   always_comb begin
      opc_field = word[INSTR_W-1:CNT_W];
      amt_m1    = word[CNT_W-1:0];
      hit       = valid && (opc_field == OPC_VAL);
   end

endmodule

// File: rtl/prs_shifter.sv
module prs_shifter #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 4,
   parameter int STYLE  = 0
) (
   input  logic [DATA_W-1:0] din,
   input  logic [CNT_W-1:0]  amt_m1,
   output logic [DATA_W-1:0] dout,
   output logic              last_out
);

   // The amount is (amt_m1 + 1). Shift by amt_m1 first; bit 0 of that
   // partial result is the last bit to leave, then one fixed step follows.
   logic [DATA_W-1:0] partial;

   if ((1 << CNT_W) > DATA_W) begin : g_bad_range
      $error("prs_shifter: shift range exceeds data width");
   end

   if (STYLE == 0) begin : g_staged
      logic [DATA_W-1:0] stage [0:CNT_W];
      assign stage[0] = din;
      for (genvar k = 0; k < CNT_W; k++) begin : g_stage
         assign stage[k+1] = amt_m1[k] ? (stage[k] >> (1 << k)) : stage[k];
      end
      assign partial = stage[CNT_W];
   end else if (STYLE == 1) begin : g_direct
      assign partial = din >> amt_m1;
   end else begin : g_bad_style
      $error("prs_shifter: STYLE must be 0 or 1");
      assign partial = '0;
   end

   always_comb begin
      last_out = partial[0];
      dout     = {1'b0, partial[DATA_W-1:1]};
   end

endmodule

// File: rtl/prs_flags.sv
module prs_flags
   import pair_rshift_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] result,
   input  logic              last_out,
   output prs_flags_t        flags
);

   always_comb begin
      flags.n = result[DATA_W-1];
      flags.z = (result == '0);
      flags.c = last_out;
   end

endmodule

// File: rtl/pair_rshift_unit.sv
module pair_rshift_unit
   import pair_rshift_pkg::*;
#(
   parameter int HALF_W  = PRS_HALF_W,
   parameter int INSTR_W = PRS_INSTR_W,
   parameter int CNT_W   = PRS_CNT_W,
   parameter int RPT_W   = PRS_RPT_W,
   parameter int STYLE   = PRS_STYLE_STAGED,
   parameter logic [INSTR_W-CNT_W-1:0] OPC_VAL = 12'h569
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr_word,
   input  logic [HALF_W-1:0]  acc_in,
   input  logic [HALF_W-1:0]  prod_in,
   input  logic               n_in,
   input  logic               z_in,
   input  logic               c_in,
   input  logic [RPT_W-1:0]   rpt_in,
   output logic [HALF_W-1:0]  acc_out,
   output logic [HALF_W-1:0]  prod_out,
   output logic               n_out,
   output logic               z_out,
   output logic               c_out,
   output logic [RPT_W-1:0]   rpt_out,
   output logic               hit_out
);

   localparam int PAIR_W = 2 * HALF_W;

   if (HALF_W < 1 || RPT_W < 1) begin : g_bad_w
      $error("pair_rshift_unit: widths must be positive");
   end
   if ((1 << CNT_W) > PAIR_W) begin : g_bad_cnt
      $error("pair_rshift_unit: shift field too wide for operand");
   end

   logic              dec_hit;
   logic [CNT_W-1:0]  dec_amt;
   logic [PAIR_W-1:0] pair_in;
   logic [PAIR_W-1:0] sh_res;
   logic              sh_last;
   prs_flags_t        new_flags;

   assign pair_in = {acc_in, prod_in};

   prs_decode #(
      .INSTR_W (INSTR_W),
      .CNT_W   (CNT_W),
      .OPC_VAL (OPC_VAL)
   ) u_decode (
      .valid  (instr_valid),
      .word   (instr_word),
      .hit    (dec_hit),
      .amt_m1 (dec_amt)
   );

   prs_shifter #(
      .DATA_W (PAIR_W),
      .CNT_W  (CNT_W),
      .STYLE  (STYLE)
   ) u_shift (
      .din      (pair_in),
      .amt_m1   (dec_amt),
      .dout     (sh_res),
      .last_out (sh_last)
   );

   prs_flags #(
      .DATA_W (PAIR_W)
   ) u_flags (
      .result   (sh_res),
      .last_out (sh_last),
      .flags    (new_flags)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_out  <= '0;
         prod_out <= '0;
         n_out    <= 1'b0;
         z_out    <= 1'b0;
         c_out    <= 1'b0;
         rpt_out  <= '0;
         hit_out  <= 1'b0;
      end else if (dec_hit) begin
         acc_out  <= sh_res[PAIR_W-1:HALF_W];
         prod_out <= sh_res[HALF_W-1:0];
         n_out    <= new_flags.n;
         z_out    <= new_flags.z;
         c_out    <= new_flags.c;
         rpt_out  <= '0;
         hit_out  <= 1'b1;
      end else begin
         acc_out  <= acc_in;
         prod_out <= prod_in;
         n_out    <= n_in;
         z_out    <= z_in;
         c_out    <= c_in;
         rpt_out  <= rpt_in;
         hit_out  <= 1'b0;
      end
   end

   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      hit_out |-> $past(instr_valid)); // R1

   AST_SHIFT_BY_ONE: assert property (@(posedge clk) disable iff (rst)
      (dec_hit && dec_amt == '0) |=>
         ({acc_out, prod_out} == ($past(pair_in) >> 1))); // R3

   AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
      dec_hit |=> !n_out && !acc_out[HALF_W-1]); // R5

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
      dec_hit |=> (z_out == (acc_out == '0 && prod_out == '0))); // R6

   AST_REPEAT_CLEARED: assert property (@(posedge clk) disable iff (rst)
      dec_hit |=> (rpt_out == '0)); // R7

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
      !dec_hit |=> (acc_out == $past(acc_in) && prod_out == $past(prod_in)
                    && rpt_out == $past(rpt_in) && !hit_out
                    && n_out == $past(n_in) && z_out == $past(z_in)
                    && c_out == $past(c_in))); // R8

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (acc_out == '0 && prod_out == '0 && rpt_out == '0
               && !n_out && !z_out && !c_out && !hit_out)); // R10

endmodule

// File: tb/pair_rshift_unit_test.sv
`timescale 1ns/1ps
module pair_rshift_unit_test;

   localparam logic [11:0] OPC = 12'h569;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        instr_valid = 1'b0;
   logic [15:0] instr_word = '0;
   logic [31:0] acc_in = '0, prod_in = '0;
   logic        n_in = 1'b0, z_in = 1'b0, c_in = 1'b0;
   logic [7:0]  rpt_in = '0;
   logic [31:0] acc_out, prod_out;
   logic        n_out, z_out, c_out, hit_out;
   logic [7:0]  rpt_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pair_rshift_unit uut (
      .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
      .acc_in(acc_in), .prod_in(prod_in), .n_in(n_in), .z_in(z_in), .c_in(c_in),
      .rpt_in(rpt_in), .acc_out(acc_out), .prod_out(prod_out), .n_out(n_out),
      .z_out(z_out), .c_out(c_out), .rpt_out(rpt_out), .hit_out(hit_out)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one word on a falling edge; the result is registered on the
   // next rising edge and sampled at the falling edge that follows.
   task automatic apply(input logic v, input logic [15:0] w, input logic [63:0] pair,
                        input logic [2:0] fl, input logic [7:0] rc);
      @(negedge clk);
      instr_valid = v;
      instr_word  = w;
      {acc_in, prod_in} = pair;
      {n_in, z_in, c_in} = fl;
      rpt_in = rc;
      @(negedge clk);
   endtask

   task automatic run_shift(input logic [63:0] pair, input int amt, input logic [7:0] rc);
      logic [63:0] er;
      logic        ec;
      er = pair >> amt;
      ec = pair[amt-1];
      apply(1'b1, {OPC, 4'(amt - 1)}, pair, 3'b101, rc);   // R2: field holds amt-1
      chk("R1 hit", {63'b0, hit_out}, 64'd1);
      chk("R2 R3 result", {acc_out, prod_out}, er);
      chk("R4 carry", {63'b0, c_out}, {63'b0, ec});
      chk("R5 negative", {63'b0, n_out}, {63'b0, er[63]});
      chk("R6 zero", {63'b0, z_out}, {63'b0, (er == 64'd0)});
      chk("R7 repeat", {56'b0, rpt_out}, 64'd0);
   endtask

   task automatic run_pass(input logic v, input logic [15:0] w, input logic [63:0] pair,
                           input logic [2:0] fl, input logic [7:0] rc);
      apply(v, w, pair, fl, rc);
      chk("R1 no hit", {63'b0, hit_out}, 64'd0);
      chk("R8 pair", {acc_out, prod_out}, pair);
      chk("R8 flags", {61'b0, n_out, z_out, c_out}, {61'b0, fl});
      chk("R8 repeat", {56'b0, rpt_out}, {56'b0, rc});
   endtask

   function automatic logic [63:0] pattern(input int idx, input logic [63:0] seed);
      case (idx)
         0: return '1;
         1: return '0;
         2: return 64'h5555_5555_5555_5555;
         3: return 64'hAAAA_AAAA_AAAA_AAAA;
         4: return 64'h8000_0000_0000_0000;
         5: return 64'h0000_0001_8000_0000;
         6: return 64'h0000_0000_0000_FFFF;
         default: return seed;
      endcase
   endfunction

   initial begin
      logic [63:0] x;
      x = 64'h0123_4567_89AB_CDEF;
      // R10: reset with busy inputs clears all outputs
      instr_valid = 1'b1; instr_word = {OPC, 4'h3};
      {acc_in, prod_in} = '1; {n_in, z_in, c_in} = 3'b111; rpt_in = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 reset outputs", {acc_out, prod_out}, 64'd0);
      chk("R10 reset flags", {56'b0, rpt_out, hit_out, n_out, z_out, c_out}, 64'd0);
      rst = 1'b0;

      // Pattern sweep over all sixteen amounts (R2 R3 R4 R5 R6 R7)
      for (int p = 0; p < 24; p++) begin
         x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
         for (int a = 1; a <= 16; a++)
            run_shift(pattern(p, x), a, 8'(p * 11 + a));
      end

      // Carry and zero boundary at each amount (R4 R6)
      for (int a = 1; a <= 16; a++) begin
         run_shift(64'd1 << (a - 1), a, 8'hFF);
         run_shift(64'd1 << a, a, 8'h01);
      end

      // Near-miss opcodes: each opcode bit flipped (R1 R8)
      for (int b = 0; b < 12; b++)
         run_pass(1'b1, {OPC ^ (12'd1 << b), 4'(b)}, 64'hDEAD_BEEF_0BAD_F00D ^ 64'(b), 3'(b), 8'(b + 3));
      // Strobe low with a matching word (R8)
      run_pass(1'b0, {OPC, 4'h7}, 64'hFEDC_BA98_7654_3210, 3'b010, 8'h42);

      // R9: no change before the clock edge, result one edge later
      @(negedge clk);
      instr_valid = 1'b1; instr_word = {OPC, 4'hF};
      {acc_in, prod_in} = 64'hFFFF_0000_0000_0000; rpt_in = 8'h09;
      #1;
      chk("R9 before edge hit", {63'b0, hit_out}, 64'd0);
      chk("R9 before edge pair", {acc_out, prod_out}, 64'hFEDC_BA98_7654_3210);
      @(negedge clk);
      chk("R9 after edge pair", {acc_out, prod_out}, 64'h0000_FFFF_0000_0000);

      // R10: reset mid-run
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R10 mid-run reset", {24'b0, rpt_out, acc_out}, 64'd0);
      rst = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule